// File: doc/BRIEF.md
# FIFO Command Processor Bridge

This block interprets a stream of 16-bit command words taken from an inbound host FIFO and carries them out against a small set of addressed ports. Any reply words go into an outbound host FIFO. Each command word has an opcode in its upper byte and an argument in its lower byte. The argument is either a port address or a ping payload. The commands are:

- an echo (ping),
- a counted burst write to a port,
- a counted burst read from a port,
- a single readiness poll,
- an open-ended stream that keeps reading a port until the host sends another word.

The inbound FIFO is read in show-ahead fashion: `cmd_data` is valid whenever `cmd_empty` is low, and `cmd_pop` consumes that word in the same cycle. Replies are written with `rsp_push` and are held back while `rsp_full` is high. All ports share one write-data bus, and each port has its own write strobe. Each port supplies its own read data and ready flag. A one-cycle read strobe tells the addressed port that its current word has been taken.

All handshake outputs are combinational functions of the registered state and the current inputs. An action therefore completes in the same cycle that its conditions are met.

Top module: `fifo_cmd_bridge`

## Requirements
- R1: After reset the block is idle. While the inbound FIFO is empty it raises no pop, no push and no port strobe.
- R2: A word with opcode 0x01 is popped, and the identical 16-bit word is pushed as a reply in that same cycle.
- R3: Opcode 0x03 with address A is followed by a count word N. The next N inbound words are each popped and placed on `port_wdata`, with bit A of `port_wstrobe` high for exactly that cycle, in arrival order.
- R4: Opcode 0x02 with address A is followed by a count word N. N words are then taken from port A, only in cycles where its ready bit is high. Each word taken raises bit A of `port_rstrobe` and pushes that port's data, in the same cycle and in order.
- R5: Opcode 0x04 with address A pushes exactly one reply: 0xFF01 when port A is ready and 0xFF00 otherwise. It strobes no port.
- R6: Opcode 0x05 with address A forwards one word from port A in each cycle in which A is ready, the reply FIFO has room and the inbound FIFO is empty. Each forwarded word raises the read strobe.
- R7: While a stream is running, any inbound word ends it. That word is popped in a cycle with no port strobe and no push, is not executed, and the following word is decoded as a fresh command.
- R8: A count word of 0x0000 in a read or write command ends that command at once, without any port strobe.
- R9: A word whose opcode is none of 0x01 to 0x05, including 0x0000, is popped and produces no reply and no strobe.
- R10: No push happens while `rsp_full` is high. A ping, poll or port read that needs a reply waits, with no pop and no strobe, until there is room.
- R11: An address at or above NPORTS selects no port. Such a port is never ready, gets no strobes, and a poll of it returns 0xFF00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_data | input | 16 | Head word of the inbound FIFO |
| cmd_empty | input | 1 | Inbound FIFO has no word |
| cmd_pop | output | 1 | Consume the head inbound word this cycle |
| rsp_data | output | 16 | Reply word |
| rsp_push | output | 1 | Write `rsp_data` into the reply FIFO this cycle |
| rsp_full | input | 1 | Reply FIFO cannot accept a word |
| port_wdata | output | 16 | Shared write data for all ports |
| port_wstrobe | output | NPORTS | One-cycle write strobe per port |
| port_rdata | input | NPORTS*16 | Read data, port p in bits 16p+15:16p |
| port_ready | input | NPORTS | Port has a word available |
| port_rstrobe | output | NPORTS | One-cycle read acknowledge per port |

## Verification
The bench builds the block with NPORTS = 3. With that value, every address from 3 to 255 lies outside the port set, so polls and streams on unselected addresses (R11) can be exercised alongside real ports. Three ports are also enough to show that strobes land only on the addressed one. A per-cycle behavioural model follows the command sequence while the port ready flags and the reply-full flag toggle under the bench's control. This brings stalls in the middle of bursts and streams (R10), and stream termination by an unrelated word (R7), into reach.

// File: rtl/fcb_pkg.sv
package fcb_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COUNT,
        ST_WRITE,
        ST_READ,
        ST_STREAM
    } fcb_state_e;

    localparam logic [7:0] OP_PING   = 8'h01;
    localparam logic [7:0] OP_READ   = 8'h02;
    localparam logic [7:0] OP_WRITE  = 8'h03;
    localparam logic [7:0] OP_POLL   = 8'h04;
    localparam logic [7:0] OP_STREAM = 8'h05;
    localparam logic [7:0] POLL_TAG  = 8'hFF;
endpackage

// File: rtl/fcb_port_mux.sv
module fcb_port_mux #(
    parameter int NPORTS = 4,
    parameter int WORD_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0]        sel_addr,
    input  logic                     rd_req,
    input  logic                     wr_req,
    input  logic [NPORTS*WORD_W-1:0] port_rdata,
    input  logic [NPORTS-1:0]        port_ready,
    output logic                     sel_ready,
    output logic [WORD_W-1:0]        sel_rdata,
    output logic [NPORTS-1:0]        port_rstrobe,
    output logic [NPORTS-1:0]        port_wstrobe
);
    logic [NPORTS-1:0] hit;

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign hit[p]          = (sel_addr == ADDR_W'(p));
        assign port_rstrobe[p] = hit[p] & rd_req;
        assign port_wstrobe[p] = hit[p] & wr_req;
    end

    assign sel_ready = |(hit & port_ready);

    always_comb begin
        sel_rdata = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (hit[p]) sel_rdata = sel_rdata | port_rdata[p*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/fifo_cmd_bridge.sv
module fifo_cmd_bridge
    import fcb_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [WORD_W-1:0]        cmd_data,
    input  logic                     cmd_empty,
    output logic                     cmd_pop,
    output logic [WORD_W-1:0]        rsp_data,
    output logic                     rsp_push,
    input  logic                     rsp_full,
    output logic [WORD_W-1:0]        port_wdata,
    output logic [NPORTS-1:0]        port_wstrobe,
    input  logic [NPORTS*WORD_W-1:0] port_rdata,
    input  logic [NPORTS-1:0]        port_ready,
    output logic [NPORTS-1:0]        port_rstrobe
);
    localparam int OPC_LSB = WORD_W - 8;

    typedef struct packed {
        fcb_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] cnt;
        logic              is_write;
    } regs_t;

    regs_t r_d, r_q;

    logic              rd_req, wr_req, sel_ready;
    logic [WORD_W-1:0] sel_rdata;
    logic [ADDR_W-1:0] sel_addr;
    logic [7:0]        opc;

    assign opc      = cmd_data[WORD_W-1:OPC_LSB];
    assign sel_addr = (r_q.st == ST_IDLE) ? cmd_data[ADDR_W-1:0] : r_q.addr;

    fcb_port_mux #(
        .NPORTS(NPORTS),
        .WORD_W(WORD_W),
        .ADDR_W(ADDR_W)
    ) u_mux (
        .sel_addr    (sel_addr),
        .rd_req      (rd_req),
        .wr_req      (wr_req),
        .port_rdata  (port_rdata),
        .port_ready  (port_ready),
        .sel_ready   (sel_ready),
        .sel_rdata   (sel_rdata),
        .port_rstrobe(port_rstrobe),
        .port_wstrobe(port_wstrobe)
    );

    always_comb begin
        r_d      = r_q;
        cmd_pop  = 1'b0;
        rsp_push = 1'b0;
        rsp_data = '0;
        rd_req   = 1'b0;
        wr_req   = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (!cmd_empty) begin
                    case (opc)
                        OP_PING: begin
                            if (!rsp_full) begin
                                cmd_pop  = 1'b1;
                                rsp_push = 1'b1;
                                rsp_data = cmd_data;
                            end
                        end
                        OP_POLL: begin
                            if (!rsp_full) begin
                                cmd_pop  = 1'b1;
                                rsp_push = 1'b1;
                                rsp_data = {POLL_TAG, 7'd0, sel_ready};
                            end
                        end
                        OP_READ, OP_WRITE: begin
                            cmd_pop    = 1'b1;
                            r_d.addr   = cmd_data[ADDR_W-1:0];
                            r_d.is_write = (opc == OP_WRITE);
                            r_d.st     = ST_COUNT;
                        end
                        OP_STREAM: begin
                            cmd_pop  = 1'b1;
                            r_d.addr = cmd_data[ADDR_W-1:0];
                            r_d.st   = ST_STREAM;
                        end
                        default: cmd_pop = 1'b1;
                    endcase
                end
            end
            ST_COUNT: begin
                if (!cmd_empty) begin
                    cmd_pop = 1'b1;
                    r_d.cnt = cmd_data;
                    if (cmd_data == '0)   r_d.st = ST_IDLE;
                    else if (r_q.is_write) r_d.st = ST_WRITE;
                    else                   r_d.st = ST_READ;
                end
            end
            ST_WRITE: begin
                if (!cmd_empty) begin
                    cmd_pop = 1'b1;
                    wr_req  = 1'b1;
                    r_d.cnt = r_q.cnt - 1'b1;
                    if (r_q.cnt == WORD_W'(1)) r_d.st = ST_IDLE;
                end
            end
            ST_READ: begin
                if (sel_ready && !rsp_full) begin
                    rd_req   = 1'b1;
                    rsp_push = 1'b1;
                    rsp_data = sel_rdata;
                    r_d.cnt  = r_q.cnt - 1'b1;
                    if (r_q.cnt == WORD_W'(1)) r_d.st = ST_IDLE;
                end
            end
            ST_STREAM: begin
                if (!cmd_empty) begin
                    cmd_pop = 1'b1;
                    r_d.st  = ST_IDLE;
                end else if (sel_ready && !rsp_full) begin
                    rd_req   = 1'b1;
                    rsp_push = 1'b1;
                    rsp_data = sel_rdata;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    assign port_wdata = wr_req ? cmd_data : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, addr: '0, cnt: '0, is_write: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    a_r1_pop_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_pop |-> !cmd_empty);

    a_r10_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_push |-> !rsp_full);

    a_r4_rstrobe_pushes_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (|port_rstrobe) |-> (rsp_push && (|(port_rstrobe & port_ready))));

    a_r3_wstrobe_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (|port_wstrobe) |-> (cmd_pop && $onehot0(port_wstrobe)));

    a_r4_rstrobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(port_rstrobe));

    a_r7_stop_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_STREAM && !cmd_empty) |-> (cmd_pop && !rsp_push && port_rstrobe == '0));

    a_r8_zero_count_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_COUNT && cmd_pop && cmd_data == '0) |=> (r_q.st == ST_IDLE));
endmodule

// File: tb/fifo_cmd_bridge_tb_top.sv
`timescale 1ns/100ps
module fifo_cmd_bridge_tb_top;
    localparam int NP = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       cmd_data = '0;
    logic              cmd_empty = 1'b1;
    logic              cmd_pop;
    logic [15:0]       rsp_data;
    logic              rsp_push;
    logic              rsp_full = 1'b0;
    logic [15:0]       port_wdata;
    logic [NP-1:0]     port_wstrobe;
    logic [NP*16-1:0]  port_rdata = '0;
    logic [NP-1:0]     port_ready = '0;
    logic [NP-1:0]     port_rstrobe;

    always #2.5 clk = ~clk;

    fifo_cmd_bridge #(.NPORTS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_data(cmd_data), .cmd_empty(cmd_empty), .cmd_pop(cmd_pop),
        .rsp_data(rsp_data), .rsp_push(rsp_push), .rsp_full(rsp_full),
        .port_wdata(port_wdata), .port_wstrobe(port_wstrobe),
        .port_rdata(port_rdata), .port_ready(port_ready), .port_rstrobe(port_rstrobe)
    );

    int vectors = 0;
    int fails = 0;

    logic [15:0] cmd_q [$];
    logic [15:0] src_q [NP][$];
    logic [NP-1:0] ready_en = '0;
    logic          full_r = 1'b0;
    logic [15:0] got_rsp [$];
    logic [15:0] exp_rsp [$];
    logic [15:0] got_wr [NP][$];

    // model state: 0 idle, 1 count, 2 write, 3 read, 4 stream
    int          m_st = 0;
    int          m_addr = 0;
    int          m_cnt = 0;
    bit          m_wr = 0;
    int          n_st, n_addr, n_cnt;
    bit          n_wr;
    bit          e_pop, e_push;
    logic [15:0] e_data, e_wdata;
    logic [NP-1:0] e_ws, e_rs;

    function automatic bit m_ready(int a);
        return (a < NP) && port_ready[a];
    endfunction

    function automatic logic [15:0] m_rdata(int a);
        return (a < NP) ? port_rdata[a*16 +: 16] : 16'h0;
    endfunction

    function automatic string st_tag(int s);
        case (s)
            1: return "R8";
            2: return "R3";
            3: return "R4";
            4: return "R6";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic model_cycle();
        int op;
        int dv;
        op = cmd_data[15:8];
        dv = cmd_data;
        e_pop = 0; e_push = 0; e_data = '0; e_wdata = '0; e_ws = '0; e_rs = '0;
        n_st = m_st; n_addr = m_addr; n_cnt = m_cnt; n_wr = m_wr;
        if (m_st == 0 && !cmd_empty) begin
            if (op == 1) begin
                if (!rsp_full) begin e_pop = 1; e_push = 1; e_data = cmd_data; end
            end else if (op == 4) begin
                if (!rsp_full) begin
                    e_pop = 1; e_push = 1;
                    e_data = m_ready(dv & 255) ? 16'hFF01 : 16'hFF00;
                end
            end else if (op == 2 || op == 3) begin
                e_pop = 1; n_addr = dv & 255; n_wr = (op == 3); n_st = 1;
            end else if (op == 5) begin
                e_pop = 1; n_addr = dv & 255; n_st = 4;
            end else begin
                e_pop = 1;
            end
        end else if (m_st == 1 && !cmd_empty) begin
            e_pop = 1; n_cnt = dv;
            n_st = (dv == 0) ? 0 : (m_wr ? 2 : 3);
        end else if (m_st == 2 && !cmd_empty) begin
            e_pop = 1; e_wdata = cmd_data;
            if (m_addr < NP) e_ws[m_addr] = 1'b1;
            n_cnt = m_cnt - 1;
            if (m_cnt == 1) n_st = 0;
        end else if (m_st == 3) begin
            if (m_ready(m_addr) && !rsp_full) begin
                e_rs[m_addr] = 1'b1; e_push = 1; e_data = m_rdata(m_addr);
                n_cnt = m_cnt - 1;
                if (m_cnt == 1) n_st = 0;
            end
        end else if (m_st == 4) begin
            if (!cmd_empty) begin
                e_pop = 1; n_st = 0;
            end else if (m_ready(m_addr) && !rsp_full) begin
                e_rs[m_addr] = 1'b1; e_push = 1; e_data = m_rdata(m_addr);
            end
        end
        if (!rst_n) begin n_st = 0; n_addr = 0; n_cnt = 0; n_wr = 0; end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        m_st = n_st; m_addr = n_addr; m_cnt = n_cnt; m_wr = n_wr;
        if (e_pop && cmd_q.size() > 0) void'(cmd_q.pop_front());
        for (int p = 0; p < NP; p++) begin
            if (e_rs[p] && src_q[p].size() > 0) void'(src_q[p].pop_front());
        end
        e_pop = 0; e_rs = '0;
        cmd_empty = (cmd_q.size() == 0);
        cmd_data  = cmd_empty ? 16'h0 : cmd_q[0];
        rsp_full  = full_r;
        for (int p = 0; p < NP; p++) begin
            port_ready[p] = ready_en[p] && (src_q[p].size() > 0);
            port_rdata[p*16 +: 16] = (src_q[p].size() > 0) ? src_q[p][0] : 16'h0;
        end
        @(negedge clk);
        model_cycle();
        vectors++;
        if (cmd_pop !== e_pop || rsp_push !== e_push || (e_push && rsp_data !== e_data) ||
            port_wstrobe !== e_ws || (|e_ws && port_wdata !== e_wdata) || port_rstrobe !== e_rs) begin
            fails++;
            $display("FAIL %s cycle actual pop=%0b push=%0b data=%h ws=%b wd=%h rs=%b expected pop=%0b push=%0b data=%h ws=%b wd=%h rs=%b",
                     st_tag(m_st), cmd_pop, rsp_push, rsp_data, port_wstrobe, port_wdata, port_rstrobe,
                     e_pop, e_push, e_data, e_ws, e_wdata, e_rs);
        end
        if (rsp_push === 1'b1) got_rsp.push_back(rsp_data);
        for (int p = 0; p < NP; p++) begin
            if (port_wstrobe[p] === 1'b1) got_wr[p].push_back(port_wdata);
        end
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic check_rsp(string tag);
        chk(got_rsp.size() == exp_rsp.size(), tag, got_rsp.size(), exp_rsp.size());
        for (int i = 0; i < exp_rsp.size() && i < got_rsp.size(); i++)
            chk(got_rsp[i] == exp_rsp[i], tag, got_rsp[i], exp_rsp[i]);
        got_rsp.delete();
        exp_rsp.delete();
    endtask

    initial begin
        #500000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        ticks(3);
        rst_n = 1'b1;
        ticks(3);
        // R1: idle, empty inbound, nothing moves
        chk(cmd_pop === 1'b0 && rsp_push === 1'b0 && port_wstrobe === '0 && port_rstrobe === '0,
            "R1", {cmd_pop, rsp_push}, 0);

        // R2: ping echoes
        cmd_q.push_back(16'h01FF); cmd_q.push_back(16'h0167);
        exp_rsp.push_back(16'h01FF); exp_rsp.push_back(16'h0167);
        ticks(5);
        check_rsp("R2");

        // R9: unknown opcodes and the zero word are dropped
        cmd_q.push_back(16'h0000); cmd_q.push_back(16'h7712); cmd_q.push_back(16'h0600);
        ticks(6);
        chk(cmd_q.size() == 0, "R9", cmd_q.size(), 0);
        check_rsp("R9");

        // R3: burst write of three words to port 1
        cmd_q.push_back(16'h0301); cmd_q.push_back(16'd3);
        for (int i = 0; i < 3; i++) cmd_q.push_back(16'h7870 + 16'(i));
        ticks(8);
        chk(got_wr[1].size() == 3, "R3", got_wr[1].size(), 3);
        for (int i = 0; i < 3 && i < got_wr[1].size(); i++)
            chk(got_wr[1][i] == 16'h7870 + 16'(i), "R3", got_wr[1][i], 16'h7870 + i);
        chk(got_wr[0].size() == 0 && got_wr[2].size() == 0, "R3", got_wr[0].size() + got_wr[2].size(), 0);
        got_wr[1].delete();

        // R4 + R10: burst read of four words from port 2 with toggling ready and full
        for (int i = 0; i < 6; i++) src_q[2].push_back(16'hBEE0 + 16'(i));
        cmd_q.push_back(16'h0202); cmd_q.push_back(16'd4);
        for (int i = 0; i < 4; i++) exp_rsp.push_back(16'hBEE0 + 16'(i));
        for (int i = 0; i < 30; i++) begin
            ready_en[2] = (i % 4 != 2);
            full_r = (i % 3 == 1);
            tick();
        end
        full_r = 1'b0;
        ready_en = '0;
        ticks(2);
        check_rsp("R4");
        chk(src_q[2].size() == 2, "R4", src_q[2].size(), 2);

        // R5 + R11: polls
        src_q[1].push_back(16'h1234);
        ready_en[1] = 1'b1;
        ticks(1);
        cmd_q.push_back(16'h0401); cmd_q.push_back(16'h0400); cmd_q.push_back(16'h0409);
        exp_rsp.push_back(16'hFF01); exp_rsp.push_back(16'hFF00); exp_rsp.push_back(16'hFF00);
        ticks(6);
        check_rsp("R5");
        chk(src_q[1].size() == 1, "R5", src_q[1].size(), 1);

        // R8: zero count write and read, then a ping
        cmd_q.push_back(16'h0301); cmd_q.push_back(16'h0000);
        cmd_q.push_back(16'h0201); cmd_q.push_back(16'h0000);
        cmd_q.push_back(16'h0155);
        exp_rsp.push_back(16'h0155);
        ticks(8);
        check_rsp("R8");
        chk(got_wr[1].size() == 0 && src_q[1].size() == 1, "R8", got_wr[1].size(), 0);
        ready_en = '0;

        // R10: ping held while reply FIFO full
        full_r = 1'b1;
        ticks(1);
        cmd_q.push_back(16'h0111);
        ticks(5);
        chk(cmd_q.size() == 1, "R10", cmd_q.size(), 1);
        chk(got_rsp.size() == 0, "R10", got_rsp.size(), 0);
        full_r = 1'b0;
        exp_rsp.push_back(16'h0111);
        ticks(4);
        check_rsp("R10");

        // R6 + R7: stream from port 0, terminator not executed
        for (int i = 0; i < 6; i++) begin
            src_q[0].push_back(16'hBAB0 + 16'(i));
            exp_rsp.push_back(16'hBAB0 + 16'(i));
        end
        cmd_q.push_back(16'h0500);
        for (int i = 0; i < 30; i++) begin
            ready_en[0] = (i % 5 != 3);
            full_r = (i % 7 == 4);
            tick();
        end
        full_r = 1'b0;
        chk(src_q[0].size() == 0, "R6", src_q[0].size(), 0);
        cmd_q.push_back(16'h0123);
        cmd_q.push_back(16'h01AA);
        exp_rsp.push_back(16'h01AA);
        ticks(6);
        check_rsp("R7");

        // R11: stream on an unselected address gets nothing
        src_q[0].push_back(16'h5555);
        ready_en = '1;
        cmd_q.push_back(16'h0507);
        ticks(8);
        chk(got_rsp.size() == 0 && src_q[0].size() == 1, "R11", got_rsp.size(), 0);
        cmd_q.push_back(16'h0000);
        ticks(4);
        chk(cmd_q.size() == 0, "R11", cmd_q.size(), 0);
        check_rsp("R11");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule